// File: doc/BRIEF.md
# Load Value Predictor with Load Classifier

This block guesses the data a load instruction will return before the memory access completes. It uses the load's instruction address to find its entry. A value table holds the last value each load slot returned, so the history depth is one. A classification table holds a 2-bit saturating confidence counter per slot. The counter decides whether the guess should be used at all. It also decides whether the load may be treated as constant, so that the cache lookup is skipped.

Both tables are direct-mapped and carry no tags. Loads whose addresses share index bits share one entry. A small fully associative constant unit remembers the data address of each load that has reached full confidence. It watches the store stream and revokes constant status when a store hits one of those addresses.

The predict lookup is combinational. A verify or a store snoop updates the state on the clock edge where it is presented. The first predict that sees the new state is the one in the cycle after that edge.

Top module: `ldval_top`

## Requirements
- R1: After reset every predict returns class 2'b00 (not predictable) and value 0, because all counters, value entries and constant entries are cleared.
- R2: The slot index is instruction address bits [IDX_BITS+1:2]. A verify writes its actual value into that slot of the value table, and the next predict to any address with the same index returns it, whether the address is the same one or an alias.
- R3: A verify whose actual value equals the stored value raises the slot's counter by one, and the counter saturates at 3.
- R4: A verify whose actual value differs from the stored value lowers the slot's counter by one, and the counter stays at 0 once there.
- R5: The predicted class is 2'b00 for counter 0 or 1. It is 2'b01 for counter 2, and also for counter 3 when the slot has no constant entry. It is 2'b10 for counter 3 with a valid constant entry. The code 2'b11 never appears. The predicted value is shown whatever the class.
- R6: When a verify leaves a counter at 3 and the slot has no constant entry, an entry holding the verify's data address and slot index is written at a round-robin pointer over CONST_ENTRIES slots. A displaced slot then reports 2'b01 while its counter stays at 3. At most one entry exists per slot index.
- R7: A snooped store whose address matches a valid constant entry invalidates that entry and sets that slot's counter to 2 (class 2'b01). The next correct verify makes the slot constant again.
- R8: A snooped store to an address held by no valid constant entry changes no class and no value.
- R9: If a snooped store has the same address as a simultaneous verify that would raise the counter to 3, the counter is held at 2 and no constant entry is made.
- R10: A wrong verify on a constant load drops its counter to 2 and removes its constant entry, so the load reports class 2'b01 with the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| predPc | input | PC_W | Instruction address of the load being predicted |
| predValue | output | DATA_W | Predicted load value |
| predClass | output | 2 | 00 not predictable, 01 predictable, 10 constant |
| verValid | input | 1 | Verify strobe for a completed load |
| verPc | input | PC_W | Instruction address of the completed load |
| verValue | input | DATA_W | Value the load actually returned |
| verAddr | input | ADDR_W | Data address the load read |
| snpValid | input | 1 | Store snoop strobe |
| snpAddr | input | ADDR_W | Data address written by the store |

## Verification
Some properties are checked on every clock. The counter must hold at its ceiling and floor. A snooped address must leave no valid constant entry behind. A slot index may own at most one constant entry. The illegal class code must never appear. A snoop that coincides with a verify at the same address must never leave a counter at 3. The scenarios in the bench show the behaviours that need a history of operations. These are the counter walking through the three classes, alias sharing of untagged slots, revocation by a matching store and immunity to a non-matching one, demotion on a wrong value, and round-robin displacement of an older constant load by newer ones.

// File: rtl/ldval_pkg.sv
package ldval_pkg;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'b00,
    CLS_PRED  = 2'b01,
    CLS_CONST = 2'b10
  } ldClassE;

  // strobes from control to datapath
  typedef struct packed {
    logic valWr;     // overwrite value slot with actual value
    logic camAlloc;  // write a constant entry at the round-robin pointer
    logic camKill;   // drop any constant entry owned by the verify slot
  } ldStrobeS;

endpackage

// File: rtl/ldval_dp.sv
module ldval_dp
  import ldval_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 32,
  parameter int IDX_BITS      = 6,
  parameter int CONST_ENTRIES = 4
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  ldStrobeS                               strobe,
  input  logic [IDX_BITS-1:0]                    predIdx,
  input  logic [IDX_BITS-1:0]                    verIdx,
  input  logic [DATA_W-1:0]                      verValue,
  input  logic [ADDR_W-1:0]                      verAddr,
  input  logic                                   snpValid,
  input  logic [ADDR_W-1:0]                      snpAddr,
  output logic [DATA_W-1:0]                      predStored,
  output logic [DATA_W-1:0]                      verStored,
  output logic                                   predCamHit,
  output logic                                   verCamHit,
  output logic [CONST_ENTRIES-1:0]               snpHitMask,
  output logic [CONST_ENTRIES-1:0][IDX_BITS-1:0] entIdx
);

  localparam int VT_DEPTH = 1 << IDX_BITS;
  localparam int PTR_W    = (CONST_ENTRIES > 1) ? $clog2(CONST_ENTRIES) : 1;

  logic [DATA_W-1:0] valTab [VT_DEPTH];
  logic [CONST_ENTRIES-1:0]             camValid;
  logic [CONST_ENTRIES-1:0][ADDR_W-1:0] camAddr;
  logic [CONST_ENTRIES-1:0][IDX_BITS-1:0] camIdx;
  logic [PTR_W-1:0] rrPtr;
  logic [PTR_W-1:0] rrNext;
  logic [CONST_ENTRIES-1:0] predMatch;
  logic [CONST_ENTRIES-1:0] verMatch;

  assign predStored = valTab[predIdx];
  assign verStored  = valTab[verIdx];
  assign entIdx     = camIdx;
  assign rrNext     = (rrPtr == PTR_W'(CONST_ENTRIES - 1)) ? '0 : rrPtr + 1'b1;

  generate
    for (genvar e = 0; e < CONST_ENTRIES; e++) begin : gMatch
      assign predMatch[e]  = camValid[e] && (camIdx[e] == predIdx);
      assign verMatch[e]   = camValid[e] && (camIdx[e] == verIdx);
      assign snpHitMask[e] = snpValid && camValid[e] && (camAddr[e] == snpAddr);
    end
  endgenerate

  assign predCamHit = |predMatch;
  assign verCamHit  = |verMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < VT_DEPTH; i++) valTab[i] <= '0;
    end else if (strobe.valWr) begin
      valTab[verIdx] <= verValue;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      camValid <= '0;
      camAddr  <= '0;
      camIdx   <= '0;
      rrPtr    <= '0;
    end else begin
      for (int e = 0; e < CONST_ENTRIES; e++) begin
        if (snpHitMask[e] || (strobe.camKill && verMatch[e])) camValid[e] <= 1'b0;
      end
      if (strobe.camAlloc) begin
        camValid[rrPtr] <= 1'b1;
        camAddr[rrPtr]  <= verAddr;
        camIdx[rrPtr]   <= verIdx;
        rrPtr           <= rrNext;
      end
    end
  end

  // checking aid: last snooped address must leave no valid entry behind
  logic              lastSnpValid;
  logic [ADDR_W-1:0] lastSnpAddr;
  logic              staleHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastSnpValid <= 1'b0;
      lastSnpAddr  <= '0;
    end else begin
      lastSnpValid <= snpValid;
      lastSnpAddr  <= snpAddr;
    end
  end

  always_comb begin
    staleHit = 1'b0;
    for (int e = 0; e < CONST_ENTRIES; e++)
      if (lastSnpValid && camValid[e] && (camAddr[e] == lastSnpAddr)) staleHit = 1'b1;
  end

  AST_SNOOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !staleHit); // R7

  AST_UNIQUE_IDX: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(predMatch)); // R6

endmodule

// File: rtl/ldval_ctrl.sv
module ldval_ctrl
  import ldval_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 32,
  parameter int IDX_BITS      = 6,
  parameter int CONST_ENTRIES = 4
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   verValid,
  input  logic [IDX_BITS-1:0]                    verIdx,
  input  logic [DATA_W-1:0]                      verValue,
  input  logic [ADDR_W-1:0]                      verAddr,
  input  logic [DATA_W-1:0]                      verStored,
  input  logic                                   verCamHit,
  input  logic                                   snpValid,
  input  logic [ADDR_W-1:0]                      snpAddr,
  input  logic [CONST_ENTRIES-1:0]               snpHitMask,
  input  logic [CONST_ENTRIES-1:0][IDX_BITS-1:0] entIdx,
  input  logic [IDX_BITS-1:0]                    predIdx,
  input  logic                                   predCamHit,
  output ldStrobeS                               strobe,
  output logic [1:0]                             predClass
);

  localparam int VT_DEPTH = 1 << IDX_BITS;

  logic [1:0] cnt [VT_DEPTH];
  logic [1:0] oldCnt;
  logic [1:0] nextCnt;
  logic       correct;
  logic       snoopBlock;
  logic [1:0] predCnt;

  assign oldCnt     = cnt[verIdx];
  assign correct    = (verStored == verValue);
  assign snoopBlock = snpValid && (snpAddr == verAddr);

  always_comb begin
    if (correct) nextCnt = (oldCnt == 2'd3) ? 2'd3 : oldCnt + 2'd1;
    else         nextCnt = (oldCnt == 2'd0) ? 2'd0 : oldCnt - 2'd1;
    if (snoopBlock && nextCnt == 2'd3) nextCnt = 2'd2;
  end

  always_comb begin
    strobe.valWr    = verValid;
    strobe.camAlloc = verValid && (nextCnt == 2'd3) && !verCamHit;
    strobe.camKill  = verValid && (nextCnt != 2'd3);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < VT_DEPTH; i++) cnt[i] <= 2'd0;
    end else begin
      if (verValid) cnt[verIdx] <= nextCnt;
      for (int e = 0; e < CONST_ENTRIES; e++)
        if (snpHitMask[e]) cnt[entIdx[e]] <= 2'd2;
    end
  end

  assign predCnt = cnt[predIdx];

  always_comb begin
    unique case (predCnt)
      2'd0, 2'd1: predClass = CLS_NONE;
      2'd2:       predClass = CLS_PRED;
      default:    predClass = predCamHit ? CLS_CONST : CLS_PRED;
    endcase
  end

  AST_CNT_CEILING: assert property (@(posedge clk) disable iff (!rstN)
    (verValid && correct && !snpValid && cnt[verIdx] == 2'd3)
      |=> cnt[$past(verIdx)] == 2'd3); // R3

  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    (verValid && !correct && !snpValid && cnt[verIdx] == 2'd0)
      |=> cnt[$past(verIdx)] == 2'd0); // R4

  AST_SNOOP_CAP: assert property (@(posedge clk) disable iff (!rstN)
    (verValid && snoopBlock) |=> cnt[$past(verIdx)] != 2'd3); // R9

endmodule

// File: rtl/ldval_top.sv
module ldval_top
  import ldval_pkg::*;
#(
  parameter int PC_W          = 32,
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 32,
  parameter int IDX_BITS      = 6,
  parameter int CONST_ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   predPc,
  output logic [DATA_W-1:0] predValue,
  output logic [1:0]        predClass,
  input  logic              verValid,
  input  logic [PC_W-1:0]   verPc,
  input  logic [DATA_W-1:0] verValue,
  input  logic [ADDR_W-1:0] verAddr,
  input  logic              snpValid,
  input  logic [ADDR_W-1:0] snpAddr
);

  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_BITS + IDX_LO - 1;

  logic [IDX_BITS-1:0] predIdx;
  logic [IDX_BITS-1:0] verIdx;
  logic [DATA_W-1:0]   verStored;
  logic                predCamHit;
  logic                verCamHit;
  logic [CONST_ENTRIES-1:0]               snpHitMask;
  logic [CONST_ENTRIES-1:0][IDX_BITS-1:0] entIdx;
  ldStrobeS            strobe;
  logic                unusedPcBits;

  assign predIdx      = predPc[IDX_HI:IDX_LO];
  assign verIdx       = verPc[IDX_HI:IDX_LO];
  assign unusedPcBits = ^{predPc[PC_W-1:IDX_HI+1], predPc[IDX_LO-1:0],
                          verPc[PC_W-1:IDX_HI+1], verPc[IDX_LO-1:0]};

  ldval_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_BITS(IDX_BITS), .CONST_ENTRIES(CONST_ENTRIES)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .verValid(verValid), .verIdx(verIdx), .verValue(verValue), .verAddr(verAddr),
    .verStored(verStored), .verCamHit(verCamHit),
    .snpValid(snpValid), .snpAddr(snpAddr), .snpHitMask(snpHitMask), .entIdx(entIdx),
    .predIdx(predIdx), .predCamHit(predCamHit),
    .strobe(strobe), .predClass(predClass)
  );

  ldval_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_BITS(IDX_BITS), .CONST_ENTRIES(CONST_ENTRIES)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .predIdx(predIdx), .verIdx(verIdx), .verValue(verValue), .verAddr(verAddr),
    .snpValid(snpValid), .snpAddr(snpAddr),
    .predStored(predValue), .verStored(verStored),
    .predCamHit(predCamHit), .verCamHit(verCamHit),
    .snpHitMask(snpHitMask), .entIdx(entIdx)
  );

  AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    predClass != 2'b11); // R5

endmodule

// File: tb/sim_ldval_top.sv
module sim_ldval_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] predPc = '0;
  logic [31:0] predValue;
  logic [1:0]  predClass;
  logic        verValid = 1'b0;
  logic [31:0] verPc = '0;
  logic [31:0] verValue = '0;
  logic [31:0] verAddr = '0;
  logic        snpValid = 1'b0;
  logic [31:0] snpAddr = '0;

  int  nRun = 0;
  int  nFail = 0;
  bit  finished = 1'b0;

  logic [1:0]  qCls [$];
  logic [31:0] qVal [$];
  string       qTag [$];

  always #2.5 clk = ~clk;

  ldval_top u0 (
    .clk(clk), .rstN(rstN),
    .predPc(predPc), .predValue(predValue), .predClass(predClass),
    .verValid(verValid), .verPc(verPc), .verValue(verValue), .verAddr(verAddr),
    .snpValid(snpValid), .snpAddr(snpAddr)
  );

  // driver: present a lookup and queue what it must return
  task automatic expectPred(input logic [31:0] pc, input logic [1:0] cls,
                            input logic [31:0] val, input string tag);
    @(negedge clk);
    predPc = pc;
    qCls.push_back(cls);
    qVal.push_back(val);
    qTag.push_back(tag);
  endtask

  task automatic doVerify(input logic [31:0] pc, input logic [31:0] val,
                          input logic [31:0] addr, input bit withSnoop);
    @(negedge clk);
    verValid = 1'b1; verPc = pc; verValue = val; verAddr = addr;
    snpValid = withSnoop; snpAddr = addr;
    @(negedge clk);
    verValid = 1'b0; snpValid = 1'b0;
  endtask

  task automatic doSnoop(input logic [31:0] addr);
    @(negedge clk);
    snpValid = 1'b1; snpAddr = addr;
    @(negedge clk);
    snpValid = 1'b0;
  endtask

  // first write, then three matches: counter 0 -> 1 -> 2 -> 3
  task automatic makeConst(input logic [31:0] pc, input logic [31:0] val,
                           input logic [31:0] addr);
    for (int k = 0; k < 4; k++) doVerify(pc, val, addr, 1'b0);
  endtask

  // monitor: compare while the lookup is stable, one ns after the driving edge
  always @(negedge clk) begin
    #1;
    if (qCls.size() > 0) begin
      logic [1:0]  eCls;
      logic [31:0] eVal;
      string       eTag;
      eCls = qCls.pop_front();
      eVal = qVal.pop_front();
      eTag = qTag.pop_front();
      nRun++;
      if (predClass !== eCls || predValue !== eVal) begin
        nFail++;
        $display("FAIL %s: class=%b value=%h expected class=%b value=%h",
                 eTag, predClass, predValue, eCls, eVal);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      nRun++; nFail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    expectPred(32'h100, 2'b00, 32'h0, "R1 reset slot0");
    expectPred(32'h3FC, 2'b00, 32'h0, "R1 reset last slot");

    // A: pc 0x100, slot 0; data address 0x8000
    doVerify(32'h100, 32'h1234, 32'h8000, 1'b0);          // mismatch at 0 stays 0
    expectPred(32'h100, 2'b00, 32'h1234, "R2 R4 written, floor");
    expectPred(32'h200, 2'b00, 32'h1234, "R2 alias shares slot");
    doVerify(32'h100, 32'h1234, 32'h8000, 1'b0);          // 1
    expectPred(32'h100, 2'b00, 32'h1234, "R3 count 1");
    doVerify(32'h100, 32'h1234, 32'h8000, 1'b0);          // 2
    expectPred(32'h100, 2'b01, 32'h1234, "R3 R5 count 2");
    doVerify(32'h100, 32'h1234, 32'h8000, 1'b0);          // 3, entry slot0
    expectPred(32'h100, 2'b10, 32'h1234, "R5 R6 constant");
    doVerify(32'h100, 32'h1234, 32'h8000, 1'b0);          // saturate
    expectPred(32'h100, 2'b10, 32'h1234, "R3 saturate");

    doSnoop(32'h9000);
    expectPred(32'h100, 2'b10, 32'h1234, "R8 unrelated store");
    doSnoop(32'h8000);                                    // revoke
    expectPred(32'h100, 2'b01, 32'h1234, "R7 store revokes");
    doVerify(32'h100, 32'h1234, 32'h8000, 1'b0);          // entry slot1
    expectPred(32'h100, 2'b10, 32'h1234, "R7 regained");

    doVerify(32'h100, 32'h5555, 32'h8000, 1'b0);          // wrong -> 2, slot1 dropped
    expectPred(32'h100, 2'b01, 32'h5555, "R10 demoted");
    doVerify(32'h100, 32'h5555, 32'h8000, 1'b0);          // 3, entry slot2
    expectPred(32'h100, 2'b10, 32'h5555, "R10 back to constant");

    // C: pc 0x108, slot 2
    doVerify(32'h108, 32'h7, 32'hA000, 1'b0);             // 0
    doVerify(32'h108, 32'h7, 32'hA000, 1'b0);             // 1
    doVerify(32'h108, 32'h7, 32'hA000, 1'b0);             // 2
    doVerify(32'h108, 32'h7, 32'hA000, 1'b1);             // would be 3, store same addr
    expectPred(32'h108, 2'b01, 32'h7, "R9 held at 2");
    doVerify(32'h108, 32'h7, 32'hA000, 1'b0);             // 3, entry slot3
    expectPred(32'h108, 2'b10, 32'h7, "R9 later constant");

    // three more constant loads fill entry slots 0,1,2; slot2 held A
    makeConst(32'h10C, 32'hD0, 32'hB000);
    makeConst(32'h110, 32'hE0, 32'hB004);
    makeConst(32'h114, 32'hF0, 32'hB008);
    expectPred(32'h100, 2'b01, 32'h5555, "R6 oldest displaced");
    expectPred(32'h108, 2'b10, 32'h7, "R6 survivor kept");
    expectPred(32'h114, 2'b10, 32'hF0, "R6 newest held");
    expectPred(32'h10C, 2'b10, 32'hD0, "R6 reused free slot");
    expectPred(32'h208, 2'b10, 32'h7, "R2 alias sees constant");

    doSnoop(32'hB004);
    expectPred(32'h110, 2'b01, 32'hE0, "R7 second revoke");
    expectPred(32'h114, 2'b10, 32'hF0, "R8 neighbour untouched");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule